// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Synthesizer

This block makes two sampled cosine waveforms with no processor in the loop once its settings are written. A divider slows the reference clock by an integer factor from 1 to 8. Each divided tick adds a 16-bit frequency step to a 16-bit phase accumulator. The eight most significant accumulator bits select an entry of a cosine table that is computed when the design is elaborated.

Both channels share the table sample, so they always run at the same frequency. Each channel applies its own conditioning in a fixed order: an arithmetic right shift for amplitude, then one of four bit-inversion modes, then an 8-bit DC offset added modulo 256. The result is an 8-bit code for a downstream converter.

The output frequency is f_clk / (div+1) × step / 65536. Settings are loaded through a single write port: one write per cycle, one register per write.

Top module: `tone_synth`

## Requirements
- R1: While reset is asserted and after it is released, every setting, the prescale counter, the phase and every channel code are zero. With a step of zero the phase stays at 0.
- R2: While the tone enable is set, the phase grows by the step exactly once every div+1 clocks, wrapping modulo 65536. While the tone enable is clear, both the phase and the prescale counter hold their values.
- R3: When the step divides 65536, an enabled channel repeats with a period of (div+1) × 65536 / step clocks.
- R4: The table sample for index k = phase[15:8] is round(127·cos(2πk/256)) in two's complement. It is exact at k = 0, 64, 128 and 192 (127, 0, −127, 0). Elsewhere it is within ±1 of that value.
- R5: Scale code s (0..3) shifts the signed sample right arithmetically by s bits. A sample of 127 therefore gives 127, 63, 31 and 15, and a sample of −127 shifted by 3 gives −16.
- R6: Invert code 00 passes the scaled value unchanged, 01 flips all eight bits, 10 flips bit 7 only and 11 flips bits 6..0 only. Code 10 turns the two's-complement sample into offset-binary form.
- R7: After inversion, the channel offset is added modulo 256, for example 0x7F + 0x90 = 0x0F.
- R8: A channel whose own enable or the tone enable is clear outputs exactly its offset value.
- R9: Both channels use the same phase. Each channel's enable, scale, invert and offset affect only its own code.
- R10: A new step or divider value takes effect at the next accumulator update and does not reset the phase.
- R11: Register map:
  - Address 0: bit 0 is the tone enable and bits 3:1 are the divider.
  - Address 1: the 16-bit step.
  - Address 2+c (channel c): bit 0 is the enable, bits 2:1 the scale, bits 4:3 the invert code and bits 15:8 the offset.
  
  A write sampled at one rising edge changes the channel code at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 2 | Register address (see R11) |
| wr_data | input | 16 | Write data |
| chan_code | output | 16 | Channel codes; channel c occupies bits [8c+7:8c] |

## Verification
The checker module checks the following on every clock:
- the phase only ever moves by exactly the current step;
- phase and counter freeze while the tone is off;
- the prescale counter wraps after reaching the divider;
- an idle channel sits at its offset;
- scale code 3 keeps the code inside [−16, 15];
- at table index 0, the MSB-flip mode gives 0xFF.

The bench's scenarios alone can show:
- the actual cosine values;
- the output period for several step/divider pairs;
- that a setting change keeps the phase;
- that the two channels stay independent under random setting traffic.

These are checked against a cycle model built from the requirements.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ALL  = 2'b01,
        INV_TOP  = 2'b10,
        INV_LOW  = 2'b11
    } inv_mode_e;

    typedef struct packed {
        logic [CODE_W-1:0] offset;
        inv_mode_e         inv;
        logic [1:0]        scale;
        logic              en;
    } chan_cfg_t;

endpackage

// File: rtl/tone_cfg_regs.sv
module tone_cfg_regs
    import tone_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int DIV_W  = 3,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [ACC_W-1:0]        wr_data,
    output logic                    tone_en,
    output logic [DIV_W-1:0]        div,
    output logic [ACC_W-1:0]        step,
    output chan_cfg_t [NUM_CH-1:0]  ch_cfg
);

    localparam int OFF_LSB = 8;

    typedef struct packed {
        logic                   tone_en;
        logic [DIV_W-1:0]       div;
        logic [ACC_W-1:0]       step;
        chan_cfg_t [NUM_CH-1:0] ch;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(0)) begin
                regs_d.tone_en = wr_data[0];
                regs_d.div     = wr_data[DIV_W:1];
            end
            if (wr_addr == ADDR_W'(1)) begin
                regs_d.step = wr_data;
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_addr == ADDR_W'(c + 2)) begin
                    regs_d.ch[c].en     = wr_data[0];
                    regs_d.ch[c].scale  = wr_data[2:1];
                    regs_d.ch[c].inv    = inv_mode_e'(wr_data[4:3]);
                    regs_d.ch[c].offset = wr_data[OFF_LSB +: CODE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tone_en = regs_q.tone_en;
    assign div     = regs_q.div;
    assign step    = regs_q.step;
    assign ch_cfg  = regs_q.ch;

endmodule

// File: rtl/tone_phase_gen.sv
module tone_phase_gen #(
    parameter int ACC_W = 16,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_en,
    input  logic [DIV_W-1:0] div,
    input  logic [ACC_W-1:0] step,
    output logic [DIV_W-1:0] cnt,
    output logic [ACC_W-1:0] phase
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [ACC_W-1:0] phase;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (tone_en) begin
            // a compare by >= lets a smaller divider take hold at once
            if (acc_q.cnt >= div) begin
                acc_d.cnt   = '0;
                acc_d.phase = acc_q.phase + step;
            end else begin
                acc_d.cnt = acc_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign cnt   = acc_q.cnt;
    assign phase = acc_q.phase;

endmodule

// File: rtl/tone_cos_lut.sv
module tone_cos_lut #(
    parameter int LUT_AW = 8,
    parameter int W      = 8
) (
    input  logic [LUT_AW-1:0] idx,
    output logic [W-1:0]      sample
);

    localparam int    DEPTH = 1 << LUT_AW;
    localparam int    QTR   = DEPTH / 4;
    localparam int    FRAC  = 20;
    localparam longint ONE  = 64'sd1 << FRAC;
    localparam longint PI_Q = 64'sd3294199;
    localparam longint AMP  = (64'sd1 <<< (W - 1)) - 64'sd1;

    // cosine of k quarter-steps on [0, pi/2], fixed point, scaled to AMP
    function automatic longint quarter_cos(input int k);
        longint x, x2, x4, x6, x8, c;
        x  = (longint'(k) * PI_Q) / longint'(2 * QTR);
        x2 = (x * x) >>> FRAC;
        x4 = (x2 * x2) >>> FRAC;
        x6 = (x4 * x2) >>> FRAC;
        x8 = (x4 * x4) >>> FRAC;
        c  = ONE - x2 / 2 + x4 / 24 - x6 / 720 + x8 / 40320;
        return (AMP * c + (ONE >>> 1)) >>> FRAC;
    endfunction

    function automatic logic [DEPTH*W-1:0] build_table();
        logic [DEPTH*W-1:0] t;
        longint v;
        int q, r;
        t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            q = i / QTR;
            r = i % QTR;
            case (q)
                0:       v = quarter_cos(r);
                1:       v = -quarter_cos(QTR - r);
                2:       v = -quarter_cos(r);
                default: v = quarter_cos(QTR - r);
            endcase
            t[i*W +: W] = v[W-1:0];
        end
        return t;
    endfunction

    localparam logic [DEPTH*W-1:0] TABLE = build_table();

    assign sample = TABLE[idx*W +: W];

endmodule

// File: rtl/tone_chan_stage.sv
module tone_chan_stage
    import tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tone_en,
    input  chan_cfg_t         cfg,
    input  logic [CODE_W-1:0] sample,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } stage_t;

    stage_t st_d, st_q;
    logic signed [CODE_W-1:0] shaped;
    logic [CODE_W-1:0]        flipped;

    always_comb begin
        st_d   = st_q;
        shaped = $signed(sample) >>> cfg.scale;
        case (cfg.inv)
            INV_NONE: flipped = shaped;
            INV_ALL:  flipped = ~shaped;
            INV_TOP:  flipped = shaped ^ TOP_BIT;
            default:  flipped = shaped ^ ~TOP_BIT;
        endcase
        if (tone_en && cfg.en) begin
            st_d.code = flipped + cfg.offset;
        end else begin
            st_d.code = cfg.offset;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

endmodule

// File: rtl/tone_synth.sv
module tone_synth
    import tone_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int DIV_W  = 3,
    parameter int LUT_AW = 8,
    parameter int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [ACC_W-1:0]         wr_data,
    output logic [NUM_CH*CODE_W-1:0] chan_code
);

    logic                   tone_en;
    logic [DIV_W-1:0]       div_q;
    logic [ACC_W-1:0]       step_q;
    chan_cfg_t [NUM_CH-1:0] ch_cfg;
    logic [DIV_W-1:0]       cnt_q;
    logic [ACC_W-1:0]       phase_q;
    logic [CODE_W-1:0]      sample;

    tone_cfg_regs #(
        .ACC_W (ACC_W),
        .DIV_W (DIV_W),
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .tone_en(tone_en),
        .div    (div_q),
        .step   (step_q),
        .ch_cfg (ch_cfg)
    );

    tone_phase_gen #(
        .ACC_W(ACC_W),
        .DIV_W(DIV_W)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tone_en(tone_en),
        .div    (div_q),
        .step   (step_q),
        .cnt    (cnt_q),
        .phase  (phase_q)
    );

    tone_cos_lut #(
        .LUT_AW(LUT_AW),
        .W     (CODE_W)
    ) u_lut (
        .idx   (phase_q[ACC_W-1 -: LUT_AW]),
        .sample(sample)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tone_chan_stage u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .tone_en(tone_en),
            .cfg    (ch_cfg[c]),
            .sample (sample),
            .code   (chan_code[c*CODE_W +: CODE_W])
        );
    end

endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk
    import tone_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int DIV_W  = 3,
    parameter int LUT_AW = 8,
    parameter int NUM_CH = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tone_en,
    input logic [DIV_W-1:0]         div,
    input logic [ACC_W-1:0]         step,
    input logic [DIV_W-1:0]         cnt,
    input logic [ACC_W-1:0]         phase,
    input chan_cfg_t [NUM_CH-1:0]   ch_cfg,
    input logic [NUM_CH*CODE_W-1:0] chan_code
);

    // R2: any phase movement is exactly one step
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (phase == ACC_W'($past(phase) + $past(step))))
        else $error("p_phase_step_r2");

    // R2: tone off freezes the accumulator
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tone_en) |-> ($stable(phase) && $stable(cnt)))
        else $error("p_phase_hold_r2");

    // R2: counter wraps once it reaches the divider
    p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_en && cnt >= div) |=> (cnt == '0))
        else $error("p_cnt_wrap_r2");

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CODE_W-1:0] code;
        assign code = chan_code[c*CODE_W +: CODE_W];

        // R8: idle channel shows its offset
        p_idle_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !($past(tone_en) && $past(ch_cfg[c].en)) |-> (code == $past(ch_cfg[c].offset)))
            else $error("p_idle_offset_r8");

        // R5: largest shift keeps the code in [-16, 15]
        p_scale_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(tone_en && ch_cfg[c].en && ch_cfg[c].scale == 2'd3 &&
                  ch_cfg[c].inv == INV_NONE && ch_cfg[c].offset == '0)
            |-> ($signed(code) >= -8'sd16 && $signed(code) <= 8'sd15))
            else $error("p_scale_floor_r5");

        // R6: top-bit flip of the peak sample gives all ones
        p_top_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(tone_en && ch_cfg[c].en && ch_cfg[c].scale == 2'd0 &&
                  ch_cfg[c].inv == INV_TOP && ch_cfg[c].offset == '0 &&
                  phase[ACC_W-1 -: LUT_AW] == '0)
            |-> (code == 8'hFF))
            else $error("p_top_flip_r6");
    end

endmodule

bind tone_synth tone_synth_chk #(
    .ACC_W (ACC_W),
    .DIV_W (DIV_W),
    .LUT_AW(LUT_AW),
    .NUM_CH(NUM_CH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tone_en  (tone_en),
    .div      (div_q),
    .step     (step_q),
    .cnt      (cnt_q),
    .phase    (phase_q),
    .ch_cfg   (ch_cfg),
    .chan_code(chan_code)
);

// File: tb/tone_synth_bench.sv
module tone_synth_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] chan_code;

    always #5 clk = ~clk;

    tone_synth u_tone_synth (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .chan_code(chan_code)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";
    int    cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // ---- reference model built from the requirements ----
    bit        m_tone;
    bit [2:0]  m_div, m_cnt;
    bit [15:0] m_step, m_phase;
    bit        m_en[2];
    int        m_scale[2], m_inv[2], m_off[2], m_exp[2];
    bit        m_tol[2];

    function automatic int exp_sample(int k);
        real a;
        a = 2.0 * 3.141592653589793 * k / 256.0;
        return int'(127.0 * $cos(a));
    endfunction

    function automatic int chan_fn(int k, int sc, int inv, int off);
        int s, b;
        s = exp_sample(k) >>> sc;
        b = s & 255;
        case (inv)
            1:       b = b ^ 255;
            2:       b = b ^ 128;
            3:       b = b ^ 127;
            default: b = b;
        endcase
        return (b + off) & 255;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tone <= 0; m_div <= 0; m_cnt <= 0; m_step <= 0; m_phase <= 0;
            for (int c = 0; c < 2; c++) begin
                m_en[c] <= 0; m_scale[c] <= 0; m_inv[c] <= 0; m_off[c] <= 0;
                m_exp[c] <= 0; m_tol[c] <= 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (m_tone && m_en[c]) begin
                    m_exp[c] <= chan_fn(int'(m_phase[15:8]), m_scale[c], m_inv[c], m_off[c]);
                    m_tol[c] <= (m_phase[13:8] != 0);
                end else begin
                    m_exp[c] <= m_off[c];
                    m_tol[c] <= 0;
                end
            end
            if (m_tone) begin
                if (m_cnt >= m_div) begin
                    m_cnt <= 0;
                    m_phase <= m_phase + m_step;
                end else begin
                    m_cnt <= m_cnt + 3'd1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_tone <= wr_data[0]; m_div <= wr_data[3:1]; end
                    2'd1: m_step <= wr_data;
                    default: begin
                        m_en[wr_addr-2]    <= wr_data[0];
                        m_scale[wr_addr-2] <= int'(wr_data[2:1]);
                        m_inv[wr_addr-2]   <= int'(wr_data[4:3]);
                        m_off[wr_addr-2]   <= int'(wr_data[15:8]);
                    end
                endcase
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            for (int c = 0; c < 2; c++) begin
                int got, diff;
                bit ok;
                got  = int'(chan_code[c*8 +: 8]);
                diff = (got - m_exp[c]) & 255;
                ok   = (diff == 0) || (m_tol[c] && (diff == 1 || diff == 255));
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s ch%0d cycle %0d: actual=%0h expected=%0h",
                             cur_req, c, cyc, got, m_exp[c]);
                end
            end
        end
    end

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(bit [1:0] a, bit [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit [15:0] chd(bit en, int sc, int inv, int off);
        return {off[7:0], 3'b000, inv[1:0], sc[1:0], en};
    endfunction

    function automatic int ch(int c);
        return int'(chan_code[c*8 +: 8]);
    endfunction

    task automatic period(string req, bit [15:0] st, bit [2:0] dv, int expc);
        int t0, t1, lim;
        bit prev;
        wr(2'd1, st);
        wr(2'd0, {12'd0, dv, 1'b1});
        repeat (20) @(negedge clk);
        t0 = -1; t1 = -1; lim = 0;
        prev = chan_code[7];
        while (t1 < 0 && lim < 5000) begin
            @(negedge clk);
            lim++;
            if (!prev && chan_code[7]) begin
                if (t0 < 0) t0 = cyc; else t1 = cyc;
            end
            prev = chan_code[7];
        end
        check(req, t1 - t0, expc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        check("R1 reset code", int'(chan_code), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        @(negedge clk);
        check("R1 after reset", int'(chan_code), 0);

        // phase stays at 0 (step 0): sample is 127
        cur_req = "R4";
        wr(2'd0, 16'h0001);
        wr(2'd2, chd(1, 0, 0, 0));
        @(negedge clk);
        check("R4 peak sample", ch(0), 8'h7F);

        cur_req = "R5";
        for (int s = 1; s < 4; s++) begin
            wr(2'd2, chd(1, s, 0, 0));
            @(negedge clk);
            check("R5 scale shift", ch(0), 127 >> s);
        end

        cur_req = "R6";
        wr(2'd2, chd(1, 0, 1, 0)); @(negedge clk);
        check("R6 invert all", ch(0), 8'h80);
        wr(2'd2, chd(1, 0, 2, 0)); @(negedge clk);
        check("R6 invert msb", ch(0), 8'hFF);
        wr(2'd2, chd(1, 0, 3, 0)); @(negedge clk);
        check("R6 invert low", ch(0), 8'h00);

        cur_req = "R7";
        wr(2'd2, chd(1, 0, 0, 8'h90)); @(negedge clk);
        check("R7 offset wrap", ch(0), 8'h0F);
        wr(2'd2, chd(1, 0, 2, 8'h81)); @(negedge clk);
        check("R7 offset after invert", ch(0), 8'h80);

        cur_req = "R8";
        wr(2'd2, chd(0, 0, 0, 8'h5A)); @(negedge clk);
        check("R8 channel off", ch(0), 8'h5A);
        wr(2'd3, chd(1, 0, 0, 8'h33));
        wr(2'd0, 16'h0000); @(negedge clk);
        check("R8 tone off", ch(1), 8'h33);

        cur_req = "R9";
        wr(2'd0, 16'h0001); @(negedge clk);
        check("R9 ch1 active", ch(1), 8'hB2);
        check("R9 ch0 untouched", ch(0), 8'h5A);

        cur_req = "R11";
        wr(2'd2, chd(1, 0, 0, 8'h10));
        check("R11 latency old value", ch(0), 8'h5A);
        @(negedge clk);
        check("R11 new value", ch(0), 8'h8F);

        cur_req = "R4";
        wr(2'd1, 16'h4000);
        repeat (24) @(negedge clk);

        cur_req = "R2";
        wr(2'd2, chd(1, 1, 2, 8'h20));
        wr(2'd1, 16'h0100);
        wr(2'd0, {12'd0, 3'd5, 1'b1});
        repeat (100) @(negedge clk);
        wr(2'd0, {12'd0, 3'd5, 1'b0});
        repeat (20) @(negedge clk);
        wr(2'd0, {12'd0, 3'd5, 1'b1});
        repeat (40) @(negedge clk);

        cur_req = "R10";
        wr(2'd1, 16'h0333);
        repeat (30) @(negedge clk);
        wr(2'd0, {12'd0, 3'd2, 1'b1});
        repeat (30) @(negedge clk);
        wr(2'd0, {12'd0, 3'd7, 1'b1});
        repeat (3) @(negedge clk);
        wr(2'd0, {12'd0, 3'd0, 1'b1});
        repeat (30) @(negedge clk);

        cur_req = "R3";
        wr(2'd2, chd(1, 0, 2, 0));
        period("R3 step 0x1000 div 0", 16'h1000, 3'd0, 16);
        period("R3 step 0x0400 div 2", 16'h0400, 3'd2, 192);
        period("R3 step 0x0200 div 7", 16'h0200, 3'd7, 1024);

        cur_req = "R9";
        for (int i = 0; i < 300; i++) begin
            bit [1:0]  a;
            bit [15:0] d;
            a = 2'($urandom_range(0, 3));
            d = 16'($urandom);
            wr(a, d);
            repeat ($urandom_range(1, 40)) @(negedge clk);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule